// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit counter with a 16-bit companion register that serves as a capture target or a reload source. It runs from an oscillator-rate clock gated by a tick enable. In timer operation it advances once every twelve enabled ticks. In event-counter operation it advances on each falling edge of an external count pin. A second external pin acts as a capture trigger, a reload trigger or a direction control, depending on the mode selected by a set of plain control inputs.

A mode decoder picks one behaviour from the control inputs. Capture mode wraps the counter freely and can snapshot it on an external edge. Reload mode refills the counter from the companion register on overflow or on an external edge. Up/down mode takes its direction from the external pin level. A forced auto-reload mode is entered when either baud select or the clock-out enable is set. In that mode the counter advances every two ticks, refills on overflow, and drives a one-cycle baud pulse, a toggling clock output, or both.

Overflow and external events set sticky flags, which are cleared by strobes. The interrupt request combines the two flags. Software loads the counter and the companion register through write strobes that share one data bus.

Top module: `mmt_top`

## Requirements
- R1: After reset the counter, companion register, both flags, the interrupt request, the baud pulse and the clock output are all 0, and up/down counting is off.
- R2: While running with the event select low, the counter advances once per 12 enabled ticks. Ticks with tick_i low do not count. With run low, the counter holds its value and the prescaler restarts from zero. With the event select high, the counter advances once per falling edge of the count pin.
- R3: In capture mode (capsel_i=1, forced mode off), the counter wraps from 0xFFFF to 0x0000 and sets the overflow flag. With exten_i=1, a falling edge of the external pin copies the counter into the companion register and sets the external flag. In this mode updown_i has no effect.
- R4: In reload mode (capsel_i=0, updown_i=0), an overflow from 0xFFFF loads the companion value and sets the overflow flag. With exten_i=1, a falling edge of the external pin forces that load and sets the external flag.
- R5: In up/down mode (capsel_i=0, updown_i=1), the external pin selects the direction: level 1 counts up and level 0 counts down. Counting up, a step from 0xFFFF loads the companion value. Counting down, a step taken while the counter equals the companion value loads 0xFFFF. Each such wrap sets the overflow flag and toggles the external flag. In this mode the external flag does not reach irq_o.
- R6: When rxbaud_i or txbaud_i is 1, capsel_i is ignored, the counter refills from the companion register on overflow, timer steps come every 2 ticks, and each overflow gives a one-cycle baud_pulse_o. The overflow flag is not set.
- R7: With clkout_en_i=1, the counter runs in the forced auto-reload mode at the 2-tick rate and clkout_o toggles on every overflow. The overflow flag is still set unless a baud select is also active.
- R8: Both flags stay set until their clear strobe. A set in the same cycle wins over the clear. irq_o is the OR of the overflow flag and the external flag, with the R5 exclusion.
- R9: cnt_wr_i loads wr_data_i into the counter and rld_wr_i loads it into the companion register. The new value is visible on the next cycle, and a write overrides a count step or capture in the same cycle.
- R10: Both pins pass through a two-flop synchroniser. Only a falling edge (synchronised high then low) acts, so a rising edge of the external pin changes neither flag nor register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable tick, one per oscillator period |
| cnt_pin_i | input | 1 | External event pin (asynchronous) |
| ext_pin_i | input | 1 | Capture/reload trigger or direction pin (asynchronous) |
| run_i | input | 1 | Run enable |
| ctsel_i | input | 1 | 1: count pin events, 0: prescaled timer |
| exten_i | input | 1 | Enables external-pin triggers |
| capsel_i | input | 1 | 1: capture mode, 0: reload modes |
| updown_i | input | 1 | Enables pin-controlled up/down counting |
| clkout_en_i | input | 1 | Enables the clock-out toggle |
| rxbaud_i | input | 1 | Receive baud select |
| txbaud_i | input | 1 | Transmit baud select |
| cnt_wr_i | input | 1 | Counter write strobe |
| rld_wr_i | input | 1 | Companion register write strobe |
| wr_data_i | input | 16 | Write data |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| ext_clr_i | input | 1 | External flag clear strobe |
| count_o | output | 16 | Counter value |
| rld_o | output | 16 | Capture/reload register value |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| baud_pulse_o | output | 1 | One-cycle pulse per overflow in baud mode |
| clkout_o | output | 1 | Clock-out toggle |

## Verification
A wrong mode decode shows at count_o on the first step after a wrap. The counter lands on 0x0000, the companion value or 0xFFFF depending on the branch taken, so every wrap vector compares the count against the single legal landing value. A flag-logic error shows as a missing or extra irq_o in the cycle after the event. A prescaler error shifts the count after a fixed number of edges, or the number of baud pulses or clock-out toggles in a fixed window. Pin-path faults show within three cycles of a pin change, as a missed or extra register update.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MD_CAPTURE = 2'd0,
    MD_RELOAD  = 2'd1,
    MD_UPDOWN  = 2'd2,
    MD_AUTO    = 2'd3
  } mmt_mode_e;
endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic fast_i,
  output logic step_o
);
  localparam int PW = $clog2(SLOW_DIV);
  localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] div_d;
  logic [PW-1:0] lim;
  logic          at_lim;

  always_comb begin
    lim    = fast_i ? FAST_LIM : SLOW_LIM;
    at_lim = (div_q >= lim);
    div_d  = div_q;
    if (!run_i)      div_d = '0;
    else if (tick_i) div_d = at_lim ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign step_o = run_i & tick_i & at_lim;
endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int W = 16
) (
  input  mmt_mode_e      mode_i,
  input  logic           step_i,
  input  logic           up_i,
  input  logic           ext_trig_i,
  input  logic           cnt_wr_i,
  input  logic           rld_wr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [W-1:0]   cnt_i,
  input  logic [W-1:0]   rld_i,
  output logic [W-1:0]   cnt_o,
  output logic [W-1:0]   rld_o,
  output logic           wrap_o,
  output logic           ext_set_o,
  output logic           ext_tgl_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic at_top;
  logic at_rld;

  always_comb begin
    at_top    = (cnt_i == ALL_ONES);
    at_rld    = (cnt_i == rld_i);
    cnt_o     = cnt_i;
    rld_o     = rld_i;
    wrap_o    = 1'b0;
    ext_set_o = 1'b0;
    ext_tgl_o = 1'b0;
    unique case (mode_i)
      MD_CAPTURE: begin
        if (step_i) begin
          cnt_o  = cnt_i + 1'b1;
          wrap_o = at_top;
        end
        if (ext_trig_i) begin
          rld_o     = cnt_i;
          ext_set_o = 1'b1;
        end
      end
      MD_RELOAD: begin
        if (step_i) begin
          cnt_o  = at_top ? rld_i : cnt_i + 1'b1;
          wrap_o = at_top;
        end
        if (ext_trig_i) begin
          cnt_o     = rld_i;
          ext_set_o = 1'b1;
        end
      end
      MD_UPDOWN: begin
        if (step_i) begin
          if (up_i) begin
            cnt_o  = at_top ? rld_i : cnt_i + 1'b1;
            wrap_o = at_top;
          end else begin
            cnt_o  = at_rld ? ALL_ONES : cnt_i - 1'b1;
            wrap_o = at_rld;
          end
          ext_tgl_o = wrap_o;
        end
      end
      default: begin
        if (step_i) begin
          cnt_o  = at_top ? rld_i : cnt_i + 1'b1;
          wrap_o = at_top;
        end
        ext_set_o = ext_trig_i;
      end
    endcase
    if (cnt_wr_i) cnt_o = wr_data_i;
    if (rld_wr_i) rld_o = wr_data_i;
  end
endmodule

// File: rtl/mmt_top.sv
module mmt_top
  import mmt_pkg::*;
#(
  parameter int W        = 16,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2,
  parameter int STAGES   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cnt_pin_i,
  input  logic         ext_pin_i,
  input  logic         run_i,
  input  logic         ctsel_i,
  input  logic         exten_i,
  input  logic         capsel_i,
  input  logic         updown_i,
  input  logic         clkout_en_i,
  input  logic         rxbaud_i,
  input  logic         txbaud_i,
  input  logic         cnt_wr_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         ovf_clr_i,
  input  logic         ext_clr_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_flag_o,
  output logic         ext_flag_o,
  output logic         irq_o,
  output logic         baud_pulse_o,
  output logic         clkout_o
);
  localparam int NPIN    = 2;
  localparam int PIN_CNT = 0;
  localparam int PIN_EXT = 1;

  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_lvl;
  logic [NPIN-1:0] pin_prev_q;
  logic [NPIN-1:0] pin_fall;

  assign pin_raw = {ext_pin_i, cnt_pin_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    mmt_sync #(.STAGES(STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .d_i    (pin_raw[g]),
      .q_o    (pin_lvl[g])
    );
    assign pin_fall[g] = pin_prev_q[g] & ~pin_lvl[g];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= '0;
    else        pin_prev_q <= pin_lvl;
  end

  logic      baud_sel;
  logic      forced;
  logic      fast;
  mmt_mode_e mode;

  always_comb begin
    baud_sel = rxbaud_i | txbaud_i;
    forced   = baud_sel | clkout_en_i;
    fast     = baud_sel | (clkout_en_i & ~ctsel_i);
    if (forced)        mode = MD_AUTO;
    else if (capsel_i) mode = MD_CAPTURE;
    else if (updown_i) mode = MD_UPDOWN;
    else               mode = MD_RELOAD;
  end

  logic presc_step;
  logic step;
  logic ext_trig;

  mmt_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run_i),
    .tick_i (tick_i),
    .fast_i (fast),
    .step_o (presc_step)
  );

  assign step     = run_i & (ctsel_i ? pin_fall[PIN_CNT] : presc_step);
  assign ext_trig = run_i & exten_i & pin_fall[PIN_EXT];

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] rld_q, rld_d;
  logic         wrap, ext_set, ext_tgl;

  mmt_core #(.W(W)) u_core (
    .mode_i     (mode),
    .step_i     (step),
    .up_i       (pin_lvl[PIN_EXT]),
    .ext_trig_i (ext_trig),
    .cnt_wr_i   (cnt_wr_i),
    .rld_wr_i   (rld_wr_i),
    .wr_data_i  (wr_data_i),
    .cnt_i      (cnt_q),
    .rld_i      (rld_q),
    .cnt_o      (cnt_d),
    .rld_o      (rld_d),
    .wrap_o     (wrap),
    .ext_set_o  (ext_set),
    .ext_tgl_o  (ext_tgl)
  );

  logic ovf_q, ovf_d;
  logic ext_q, ext_d;
  logic baud_q, baud_d;
  logic clko_q, clko_d;

  always_comb begin
    ovf_d = ovf_q;
    if (wrap & ~baud_sel) ovf_d = 1'b1;
    else if (ovf_clr_i)   ovf_d = 1'b0;
    ext_d = ext_q;
    if (ext_set)        ext_d = 1'b1;
    else if (ext_tgl)   ext_d = ~ext_q;
    else if (ext_clr_i) ext_d = 1'b0;
    baud_d = wrap & baud_sel;
    clko_d = (wrap & clkout_en_i) ? ~clko_q : clko_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
      baud_q <= 1'b0;
      clko_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      ovf_q  <= ovf_d;
      ext_q  <= ext_d;
      baud_q <= baud_d;
      clko_q <= clko_d;
    end
  end

  assign count_o      = cnt_q;
  assign rld_o        = rld_q;
  assign ovf_flag_o   = ovf_q;
  assign ext_flag_o   = ext_q;
  assign irq_o        = ovf_q | (ext_q & (mode != MD_UPDOWN));
  assign baud_pulse_o = baud_q;
  assign clkout_o     = clko_q;
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         capsel_i,
  input logic         exten_i,
  input logic         clkout_en_i,
  input logic         rxbaud_i,
  input logic         txbaud_i,
  input logic         cnt_wr_i,
  input logic         rld_wr_i,
  input logic         ovf_clr_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] rld_o,
  input logic         ovf_flag_o,
  input logic         baud_pulse_o,
  input logic         clkout_o
);
  // R8: overflow flag holds until its clear strobe
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o && !ovf_clr_i |=> ovf_flag_o);

  // R2: a stopped counter holds unless written
  a_r2_frozen_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !cnt_wr_i |=> $stable(count_o));

  // R6: baud rollover never raises the overflow flag
  a_r6_baud_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> !$past(rxbaud_i || txbaud_i));

  // R6: a baud pulse coincides with a refill from the companion register
  a_r6_baud_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_pulse_o && !$past(cnt_wr_i) |-> count_o == $past(rld_o));

  // R7: clock output moves only while enabled
  a_r7_clkout_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clkout_o) |-> $past(clkout_en_i));

  // R9: companion register changes only by write or capture
  a_r9_rld_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rld_wr_i && !(capsel_i && exten_i) |=> $stable(rld_o));
endmodule

bind mmt_top mmt_checker #(.W(W)) u_mmt_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .capsel_i     (capsel_i),
  .exten_i      (exten_i),
  .clkout_en_i  (clkout_en_i),
  .rxbaud_i     (rxbaud_i),
  .txbaud_i     (txbaud_i),
  .cnt_wr_i     (cnt_wr_i),
  .rld_wr_i     (rld_wr_i),
  .ovf_clr_i    (ovf_clr_i),
  .count_o      (count_o),
  .rld_o        (rld_o),
  .ovf_flag_o   (ovf_flag_o),
  .baud_pulse_o (baud_pulse_o),
  .clkout_o     (clkout_o)
);

// File: tb/mmt_top_tb.sv
module mmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tick_i, cnt_pin_i, ext_pin_i, run_i, ctsel_i, exten_i;
  logic        capsel_i, updown_i, clkout_en_i, rxbaud_i, txbaud_i;
  logic        cnt_wr_i, rld_wr_i, ovf_clr_i, ext_clr_i;
  logic [15:0] wr_data_i;
  logic [15:0] count_o, rld_o;
  logic        ovf_flag_o, ext_flag_o, irq_o, baud_pulse_o, clkout_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mmt_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .ext_pin_i(ext_pin_i), .run_i(run_i), .ctsel_i(ctsel_i), .exten_i(exten_i),
    .capsel_i(capsel_i), .updown_i(updown_i), .clkout_en_i(clkout_en_i),
    .rxbaud_i(rxbaud_i), .txbaud_i(txbaud_i), .cnt_wr_i(cnt_wr_i),
    .rld_wr_i(rld_wr_i), .wr_data_i(wr_data_i), .ovf_clr_i(ovf_clr_i),
    .ext_clr_i(ext_clr_i), .count_o(count_o), .rld_o(rld_o),
    .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .irq_o(irq_o),
    .baud_pulse_o(baud_pulse_o), .clkout_o(clkout_o)
  );

  // {capsel, updown, dir, rxbaud, txbaud, start[16], reload[16], pulses[8], exp_cnt[16], ovf, ext, irq}
  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,1'b0,16'hFFFE,16'h1234,8'd3,16'h0001,1'b1,1'b0,1'b1},
    {1'b0,1'b0,1'b1,1'b0,1'b0,16'hFFFE,16'h1234,8'd3,16'h1235,1'b1,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b0,1'b0,16'hFFFF,16'h8000,8'd2,16'h8001,1'b1,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,16'h8002,16'h8000,8'd3,16'hFFFF,1'b1,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFE,8'd4,16'hFFFF,1'b1,1'b0,1'b1},
    {1'b1,1'b0,1'b1,1'b1,1'b0,16'hFFFE,16'hFF00,8'd3,16'hFF01,1'b0,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,1'b0,16'h0010,16'h0000,8'd4,16'h0014,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b0,1'b0,1'b0,16'h0005,16'h0000,8'd2,16'h0007,1'b0,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,1'b1,16'hFFFF,16'h0000,8'd1,16'h0000,1'b0,1'b0,1'b0}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 7:    return "R3";
      1:       return "R4";
      2, 3, 4: return "R5";
      5, 8:    return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [15:0] c, logic [15:0] r);
    wr_data_i = c; cnt_wr_i = 1'b1; cyc(1);
    cnt_wr_i = 1'b0; wr_data_i = r; rld_wr_i = 1'b1;
    ovf_clr_i = 1'b1; ext_clr_i = 1'b1; cyc(1);
    rld_wr_i = 1'b0; ovf_clr_i = 1'b0; ext_clr_i = 1'b0;
  endtask

  task automatic pulse_cnt(int n);
    for (int k = 0; k < n; k++) begin
      cnt_pin_i = 1'b0; cyc(4);
      cnt_pin_i = 1'b1; cyc(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b1; cnt_pin_i = 1'b1; ext_pin_i = 1'b1;
    run_i = 1'b0; ctsel_i = 1'b1; exten_i = 1'b0; capsel_i = 1'b0;
    updown_i = 1'b0; clkout_en_i = 1'b0; rxbaud_i = 1'b0; txbaud_i = 1'b0;
    cnt_wr_i = 1'b0; rld_wr_i = 1'b0; wr_data_i = '0;
    ovf_clr_i = 1'b0; ext_clr_i = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(5);
    // R1 reset state
    chk("R1 count", 32'(count_o), 32'h0);
    chk("R1 reload", 32'(rld_o), 32'h0);
    chk("R1 flags/irq", {29'd0, ovf_flag_o, ext_flag_o, irq_o}, 32'h0);
    chk("R1 baud/clkout", {30'd0, baud_pulse_o, clkout_o}, 32'h0);

    // table walk: event-counter mode
    for (int i = 0; i < NV; i++) begin
      run_i = 1'b0; ctsel_i = 1'b1; exten_i = 1'b0; clkout_en_i = 1'b0;
      capsel_i = VEC[i][63]; updown_i = VEC[i][62]; ext_pin_i = VEC[i][61];
      rxbaud_i = VEC[i][60]; txbaud_i = VEC[i][59];
      cyc(6);
      load(VEC[i][58:43], VEC[i][42:27]);
      run_i = 1'b1;
      pulse_cnt(int'(VEC[i][26:19]));
      cyc(2);
      run_i = 1'b0;
      chk({vec_req(i), " count"}, 32'(count_o), 32'(VEC[i][18:3]));
      chk({vec_req(i), " ovf"}, 32'(ovf_flag_o), 32'(VEC[i][2]));
      chk({vec_req(i), " ext"}, 32'(ext_flag_o), 32'(VEC[i][1]));
      chk({vec_req(i), " irq"}, 32'(irq_o), 32'(VEC[i][0]));
    end
    rxbaud_i = 1'b0; txbaud_i = 1'b0; capsel_i = 1'b0; updown_i = 1'b0;
    ext_pin_i = 1'b1; cyc(6);

    // R2 timer rate: 120 edges -> 10 steps
    ctsel_i = 1'b0;
    load(16'h0000, 16'h0000);
    run_i = 1'b1;
    repeat (120) @(posedge clk);
    @(negedge clk) run_i = 1'b0;
    chk("R2 timer rate", 32'(count_o), 32'd10);
    cyc(20);
    chk("R2 hold while stopped", 32'(count_o), 32'd10);
    tick_i = 1'b0; run_i = 1'b1; cyc(30); run_i = 1'b0;
    chk("R2 tick gating", 32'(count_o), 32'd10);
    tick_i = 1'b1;

    // R6 baud rate generation
    begin
      int np;
      np = 0;
      rxbaud_i = 1'b1;
      load(16'hFFFC, 16'hFFFC);
      run_i = 1'b1;
      repeat (40) begin
        @(posedge clk); @(negedge clk);
        if (baud_pulse_o) np++;
      end
      run_i = 1'b0;
      chk("R6 baud pulses", 32'(np), 32'd5);
      chk("R6 no ovf flag", 32'(ovf_flag_o), 32'd0);
      chk("R6 count after reload", 32'(count_o), 32'hFFFC);
      rxbaud_i = 1'b0;
    end

    // R7 clock-out
    begin
      int nt;
      logic prev;
      nt = 0;
      clkout_en_i = 1'b1;
      load(16'hFFFC, 16'hFFFC);
      prev = clkout_o;
      run_i = 1'b1;
      repeat (40) begin
        @(posedge clk); @(negedge clk);
        if (clkout_o != prev) nt++;
        prev = clkout_o;
      end
      run_i = 1'b0;
      chk("R7 clkout toggles", 32'(nt), 32'd5);
      chk("R7 clkout level", 32'(clkout_o), 32'd1);
      chk("R7 ovf flag", 32'(ovf_flag_o), 32'd1);
      clkout_en_i = 1'b0;
    end

    // R3 capture on external falling edge
    ctsel_i = 1'b1; capsel_i = 1'b1; exten_i = 1'b1; ext_pin_i = 1'b1; cyc(6);
    load(16'h4321, 16'h0000);
    chk("R9 count write", 32'(count_o), 32'h4321);
    run_i = 1'b1;
    ext_pin_i = 1'b0; cyc(6);
    chk("R3 capture value", 32'(rld_o), 32'h4321);
    chk("R3 ext flag", 32'(ext_flag_o), 32'd1);
    chk("R3 irq", 32'(irq_o), 32'd1);
    ext_clr_i = 1'b1; cyc(1); ext_clr_i = 1'b0;
    ext_pin_i = 1'b1; cyc(6);
    chk("R10 rising edge no flag", 32'(ext_flag_o), 32'd0);
    chk("R10 rising edge no capture", 32'(rld_o), 32'h4321);
    run_i = 1'b0;

    // R4 forced reload on external falling edge
    capsel_i = 1'b0; cyc(2);
    load(16'h0100, 16'h7777);
    chk("R9 reload write", 32'(rld_o), 32'h7777);
    run_i = 1'b1;
    ext_pin_i = 1'b0; cyc(6);
    chk("R4 ext reload", 32'(count_o), 32'h7777);
    chk("R4 ext flag", 32'(ext_flag_o), 32'd1);
    chk("R4 no ovf", 32'(ovf_flag_o), 32'd0);
    run_i = 1'b0;
    cyc(10);
    chk("R8 ext flag sticky", 32'(ext_flag_o), 32'd1);
    ext_clr_i = 1'b1; cyc(1); ext_clr_i = 1'b0;
    chk("R8 ext flag cleared", 32'(ext_flag_o), 32'd0);
    chk("R8 irq cleared", 32'(irq_o), 32'd0);

    // R5 external flag excluded from irq in up/down mode
    exten_i = 1'b0; updown_i = 1'b1; ext_pin_i = 1'b1; cyc(6);
    load(16'hFFFF, 16'h0000);
    run_i = 1'b1;
    pulse_cnt(1);
    cyc(2);
    run_i = 1'b0;
    chk("R5 up wrap count", 32'(count_o), 32'h0000);
    chk("R5 wrap flags", {30'd0, ovf_flag_o, ext_flag_o}, 32'h3);
    ovf_clr_i = 1'b1; cyc(1); ovf_clr_i = 1'b0;
    chk("R5 ext flag kept", 32'(ext_flag_o), 32'd1);
    chk("R5 irq masked", 32'(irq_o), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule